// File: doc/BRIEF.md
# Six-Channel Reference-Compare Timer Bank

This block holds six independent up-counting timers behind one small register bus. Each channel has a control word, a live count and a compare value. While a channel is enabled, its own prescaler divides the clock by a selectable power of two. On each prescaled tick the count steps up by one, and the new value is compared against the compare value. When they are equal, a match occurs. A match always records a match flag. If the channel's interrupt enable is set, it also records an interrupt flag. Depending on the mode bits, the match can also send the count back to zero or freeze the channel.

All flags live in one shared status word that is cleared by writing ones. The single interrupt output is high while any channel's interrupt flag is set. Channels 0 to 3 count with 16 bits and channels 4 and 5 count with 20 bits, so software can pick a channel by the range it needs.

Top module: `reftimer_bank`

## Requirements
- R1: Channel i's control word sits at address 0x10*i, its count at 0x10*i+4 and its compare value at 0x10*i+8, and the status word sits at 0x60. After reset every register reads 0 and `irq` is 0.
- R2: The control word fields are: bit 0 run, bit 1 restart-on-match, bit 3 interrupt enable, bits 6:4 prescale code and bit 9 freeze-on-match. Bits 2, 7 and 8 and all bits above 9 read as 0.
- R3: Prescale codes 0, 1, 2, 3, 4, 5 and 6 give one count every 2, 4, 8, 16, 32, 1024 and 4096 clocks, and code 7 behaves like code 6. After a control write that sets run and bit 8, the count after n further clock edges is floor(n / period).
- R4: Channels 0 to 3 have 16-bit count and compare registers, and channels 4 and 5 have 20-bit ones. Wider writes are truncated, and the unused upper bits read 0.
- R5: A match sets status bit 8+i whether or not interrupts are enabled. Status bit i is set only when the channel's interrupt enable is 1. Status bits 6, 7 and 14 and above read 0.
- R6: With restart-on-match set, the count returns to 0 on the tick that matches.
- R7: With freeze-on-match set, the count holds at the compare value and the run bit clears. This mode takes priority over restart-on-match.
- R8: With neither mode bit set, the count passes the compare value and wraps to 0 at its own width.
- R9: Writing a control word with bit 8 set zeroes the count and the prescaler phase in that same write. Bit 8 is not stored.
- R10: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If a match and a clear hit the same bit in the same cycle, the match wins.
- R11: `irq` is high exactly when any status bit 0 to 5 is set.
- R12: A channel whose run bit is 0 keeps its count and prescaler phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, takes effect on the clock edge |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its default parameters. That gives six channels: four with 16-bit counters, two with 20-bit counters, and a 12-bit prescaler. Because the count is writable, the bench can load values just below each width's limit, so both wrap points are reached in a few cycles. The slowest prescale of 4096 clocks per count still fits within the cycle budget, so every prescale code, including the aliased code 7, is timed exactly.

// File: rtl/reftimer_bank.sv
`timescale 1ns/1ps
module reftimer_bank #(
  parameter int NUM_CH     = 6,
  parameter int NARROW_W   = 16,
  parameter int WIDE_W     = 20,
  parameter int FIRST_WIDE = 4,
  parameter int PRE_W      = 12,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(8'h60);
  localparam int TF_LSB = 8;

  function automatic logic [3:0] shift_of(input logic [2:0] code);
    case (code)
      3'd0, 3'd1, 3'd2, 3'd3, 3'd4: shift_of = 4'(code) + 4'd1;
      3'd5:    shift_of = 4'd10;
      default: shift_of = 4'd12;
    endcase
  endfunction

  wire       stat_hit = bus_addr == STAT_ADDR;
  wire       stat_wr  = bus_we && stat_hit;
  wire [3:0] a_ch     = bus_addr[7:4];
  wire [1:0] a_reg    = bus_addr[3:2];
  wire       aligned  = bus_addr[1:0] == 2'b00;

  logic [NUM_CH-1:0] tf_v, ti_v;
  logic [DATA_W-1:0] rd_cfg [NUM_CH];
  logic [DATA_W-1:0] rd_cnt [NUM_CH];
  logic [DATA_W-1:0] rd_ref [NUM_CH];

  logic unused_wd;
  assign unused_wd = ^bus_wdata;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam int W = (i >= FIRST_WIDE) ? WIDE_W : NARROW_W;
    logic [W-1:0]     cnt, cmp;
    logic [PRE_W-1:0] pre;
    logic             run, restart, ien, freeze, tf, ti;
    logic [2:0]       sel;

    wire              hit    = bus_we && !stat_hit && aligned && a_ch == 4'(i);
    wire              wr_cfg = hit && a_reg == 2'd0;
    wire              wr_cnt = hit && a_reg == 2'd1;
    wire              wr_cmp = hit && a_reg == 2'd2;
    wire [PRE_W-1:0]  pmask  = (PRE_W'(1) << shift_of(sel)) - PRE_W'(1);
    wire              tick   = run && ((pre & pmask) == pmask);
    wire [W-1:0]      nxt    = cnt + W'(1);
    wire              match  = tick && nxt == cmp;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt <= '0; cmp <= '0; pre <= '0;
        run <= 1'b0; restart <= 1'b0; ien <= 1'b0; freeze <= 1'b0;
        sel <= '0; tf <= 1'b0; ti <= 1'b0;
      end else begin
        if (run) pre <= pre + PRE_W'(1);
        if (tick) begin
          if (match && freeze) begin
            cnt <= nxt;
            run <= 1'b0;
          end else if (match && restart) cnt <= '0;
          else cnt <= nxt;
        end
        if (wr_cfg) begin
          run     <= bus_wdata[0];
          restart <= bus_wdata[1];
          ien     <= bus_wdata[3];
          sel     <= bus_wdata[6:4];
          freeze  <= bus_wdata[9];
          if (bus_wdata[8]) begin
            cnt <= '0;
            pre <= '0;
          end
        end
        if (wr_cnt) cnt <= bus_wdata[W-1:0];
        if (wr_cmp) cmp <= bus_wdata[W-1:0];
        tf <= match || (tf && !(stat_wr && bus_wdata[TF_LSB+i]));
        ti <= (match && ien) || (ti && !(stat_wr && bus_wdata[i]));
      end
    end

    assign tf_v[i]   = tf;
    assign ti_v[i]   = ti;
    assign rd_cfg[i] = DATA_W'({freeze, 2'b00, sel, ien, 1'b0, restart, run});
    assign rd_cnt[i] = DATA_W'(cnt);
    assign rd_ref[i] = DATA_W'(cmp);
  end

  always_comb begin
    bus_rdata = '0;
    if (stat_hit) bus_rdata = DATA_W'(ti_v) | (DATA_W'(tf_v) << TF_LSB);
    else if (aligned)
      for (int i = 0; i < NUM_CH; i++)
        if (a_ch == 4'(i))
          case (a_reg)
            2'd0:    bus_rdata = rd_cfg[i];
            2'd1:    bus_rdata = rd_cnt[i];
            2'd2:    bus_rdata = rd_ref[i];
            default: bus_rdata = '0;
          endcase
  end

  assign irq = |ti_v;
endmodule

module reftimer_bank_chk #(
  parameter int NUM_CH     = 6,
  parameter int NARROW_W   = 16,
  parameter int WIDE_W     = 20,
  parameter int FIRST_WIDE = 4,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq
);
  localparam logic [DATA_W-1:0] STAT_MASK =
    DATA_W'((1 << NUM_CH) - 1) | (DATA_W'((1 << NUM_CH) - 1) << 8);
  localparam logic [DATA_W-1:0] CFG_MASK = DATA_W'(32'h27B);

  wire rd_stat = !bus_we && bus_addr == ADDR_W'(8'h60);
  wire in_ch   = !bus_we && bus_addr[1:0] == 2'b00 && 32'(bus_addr[7:4]) < NUM_CH;
  wire rd_cfg  = in_ch && bus_addr[3:2] == 2'd0;
  wire rd_val  = in_ch && (bus_addr[3:2] == 2'd1 || bus_addr[3:2] == 2'd2);
  wire narrow  = 32'(bus_addr[7:4]) < FIRST_WIDE;

  assert_irq_or_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat |-> (irq == |bus_rdata[NUM_CH-1:0]));
  assert_status_fields_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat |-> ((bus_rdata & ~STAT_MASK) == '0));
  assert_cfg_spare_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cfg |-> ((bus_rdata & ~CFG_MASK) == '0));
  assert_narrow_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_val && narrow) |-> ((bus_rdata >> NARROW_W) == '0));
  assert_wide_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_val && !narrow) |-> ((bus_rdata >> WIDE_W) == '0));
endmodule

bind reftimer_bank reftimer_bank_chk #(
  .NUM_CH(NUM_CH), .NARROW_W(NARROW_W), .WIDE_W(WIDE_W),
  .FIRST_WIDE(FIRST_WIDE), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .irq(irq)
);

// File: tb/sim_reftimer_bank.sv
`timescale 1ns/1ps
module sim_reftimer_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  reftimer_bank u0 (.clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
                    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  always #4 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;

  // behavioural reference model
  int m_cnt[6], m_ref[6], m_pre[6], m_sel[6];
  bit m_en[6], m_cont[6], m_stop[6], m_ien[6], m_tf[6], m_ti[6];

  function automatic int wmask(int i);
    return (i >= 4) ? 32'hFFFFF : 32'hFFFF;
  endfunction

  function automatic int period(int code);
    case (code)
      0: return 2;
      1: return 4;
      2: return 8;
      3: return 16;
      4: return 32;
      5: return 1024;
      default: return 4096;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 6; i++) begin
        m_cnt[i] = 0; m_ref[i] = 0; m_pre[i] = 0; m_sel[i] = 0;
        m_en[i] = 0; m_cont[i] = 0; m_stop[i] = 0; m_ien[i] = 0;
        m_tf[i] = 0; m_ti[i] = 0;
      end
    end else begin
      for (int i = 0; i < 6; i++) begin
        int per, nx, n_cnt, n_pre, a_ch, a_rg;
        bit tick, match, n_en, is_stat, is_ch;
        per = period(m_sel[i]);
        tick = m_en[i] && ((m_pre[i] % per) == per - 1);
        nx = (m_cnt[i] + 1) & wmask(i);
        match = tick && (nx == m_ref[i]);
        n_pre = m_en[i] ? (m_pre[i] + 1) % 4096 : m_pre[i];
        n_cnt = m_cnt[i];
        n_en = m_en[i];
        if (tick) begin
          if (match && m_stop[i]) begin n_cnt = nx; n_en = 0; end
          else if (match && m_cont[i]) n_cnt = 0;
          else n_cnt = nx;
        end
        is_stat = bus_we && bus_addr == 8'h60;
        a_ch = int'(bus_addr) / 16;
        a_rg = (int'(bus_addr) / 4) % 4;
        is_ch = bus_we && !is_stat && bus_addr[1:0] == 0 && a_ch == i;
        m_tf[i] = match || (m_tf[i] && !(is_stat && bus_wdata[8+i]));
        m_ti[i] = (match && m_ien[i]) || (m_ti[i] && !(is_stat && bus_wdata[i]));
        if (is_ch && a_rg == 0) begin
          n_en = bus_wdata[0]; m_cont[i] = bus_wdata[1]; m_ien[i] = bus_wdata[3];
          m_sel[i] = int'(bus_wdata[6:4]); m_stop[i] = bus_wdata[9];
          if (bus_wdata[8]) begin n_cnt = 0; n_pre = 0; end
        end
        if (is_ch && a_rg == 1) n_cnt = int'(bus_wdata) & wmask(i);
        if (is_ch && a_rg == 2) m_ref[i] = int'(bus_wdata) & wmask(i);
        m_cnt[i] = n_cnt; m_pre[i] = n_pre; m_en[i] = n_en;
      end
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic peek(input int addr, output int val);
    bus_addr = 8'(addr);
    #0.1;
    val = int'(bus_rdata);
  endtask

  task automatic check_all();
    int v, st, ti_any;
    bus_we = 1'b0;
    st = 0; ti_any = 0;
    for (int i = 0; i < 6; i++) begin
      peek(16*i, v);
      chk("R2", $sformatf("ch%0d control", i), v,
          (int'(m_stop[i]) << 9) | (m_sel[i] << 4) | (int'(m_ien[i]) << 3) |
          (int'(m_cont[i]) << 1) | int'(m_en[i]));
      peek(16*i + 4, v);
      chk("R3", $sformatf("ch%0d count", i), v, m_cnt[i]);
      peek(16*i + 8, v);
      chk("R4", $sformatf("ch%0d compare", i), v, m_ref[i]);
      st |= (int'(m_ti[i]) << i) | (int'(m_tf[i]) << (8 + i));
      ti_any |= int'(m_ti[i]);
    end
    peek(8'h60, v);
    chk("R10", "status", v, st);
    chk("R11", "irq", int'(irq), ti_any);
  endtask

  task automatic cyc(input bit we, input int addr, input int data);
    @(negedge clk);
    check_all();
    bus_we = we;
    bus_addr = 8'(addr);
    bus_wdata = data;
  endtask

  task automatic wr(input int addr, input int data);
    cyc(1, addr, data);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cyc(0, 0, 0);
  endtask

  task automatic xchk(input string tag, input int addr, input int mask, input int exp);
    int v;
    @(negedge clk);
    bus_we = 1'b0;
    peek(addr, v);
    chk(tag, $sformatf("addr 0x%0h", addr), v & mask, exp);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      finish_run();
    end
  end

  initial begin
    int held;
    idle(3);
    @(negedge clk) rst_n = 1'b1;
    // R1: reset values
    xchk("R1", 8'h60, -1, 0);
    xchk("R1", 8'h54, -1, 0);
    chk("R1", "irq after reset", int'(irq), 0);

    // R5 R6 R11: ch0 restart mode with interrupt enable, compare 5
    wr(8'h08, 5);
    wr(8'h00, 32'h0B);
    idle(14);
    wr(8'h00, 0);
    xchk("R5", 8'h60, 32'h101, 32'h101);
    chk("R11", "irq with flag", int'(irq), 1);
    xchk("R6", 8'h04, -1, 2);
    // R12: disabled channel holds its count
    peek(8'h04, held);
    idle(6);
    xchk("R12", 8'h04, -1, held);
    // R10: writing zeros keeps flags, ones clear them
    wr(8'h60, 0);
    xchk("R10", 8'h60, -1, 32'h101);
    wr(8'h60, 32'h101);
    xchk("R10", 8'h60, -1, 0);
    chk("R11", "irq after clear", int'(irq), 0);

    // R5: ch3 matches without interrupt enable
    wr(8'h38, 2);
    wr(8'h30, 32'h03);
    idle(10);
    wr(8'h30, 0);
    xchk("R5", 8'h60, 32'h808, 32'h800);
    chk("R5", "irq without enable", int'(irq), 0);
    wr(8'h60, 32'h808);

    // R7: ch1 freeze takes priority over restart, prescale code 2
    wr(8'h18, 3);
    wr(8'h10, 32'h223);
    idle(60);
    xchk("R7", 8'h14, -1, 3);
    xchk("R7", 8'h10, 1, 0);
    wr(8'h60, 32'h202);

    // R4: truncation to channel width
    wr(8'h04, 32'h12345);
    xchk("R4", 8'h04, -1, 32'h2345);
    wr(8'h44, -1);
    xchk("R4", 8'h44, -1, 32'hFFFFF);
    wr(8'h48, 32'hABCDE1);
    xchk("R4", 8'h48, -1, 32'hBCDE1);

    // R8: free-running wrap at 20 bits and at 16 bits
    wr(8'h40, 32'h01);
    idle(6);
    xchk("R8", 8'h44, 32'hFFFF0, 0);
    wr(8'h40, 0);
    wr(8'h24, 32'hFFFD);
    wr(8'h28, 32'h10);
    wr(8'h20, 32'h01);
    idle(20);
    xchk("R8", 8'h24, 32'hFFF0, 0);

    // R9: clear zeroes count and reads back 0
    wr(8'h20, 32'h101);
    xchk("R9", 8'h24, -1, 0);
    xchk("R9", 8'h20, -1, 32'h001);
    wr(8'h20, 0);

    // R3: every prescale code, three periods each
    wr(8'h08, 32'hFFFF);
    for (int code = 0; code < 8; code++) begin
      wr(8'h00, (code << 4) | 32'h101);
      idle(3 * period(code));
      xchk("R3", 8'h04, -1, 3);
      wr(8'h00, 0);
    end
    idle(4);
    finish_run();
  end
endmodule